// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog whose single 16-bit control word is protected against stray software writes. A new control value is taken only after the two-word unlock key, and the running count is restarted only by a second, separate two-word service key. Any other write is ignored. A write that breaks a key sequence part way also has no effect and returns the tracker to its idle state.

The control word has two enable bits in its top positions and a one-hot timeout field in its low-order bits. When the count reaches the selected power-of-two period while counting is enabled, the block raises a sticky expiry flag. If the reset action is also enabled, it drives a one-cycle reset pulse. The counter then wraps, so an unserviced watchdog keeps expiring once per period. Software changes the period by first writing the unlock key and zero, then the unlock key and the new word.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, and while reset is held, `wdt_rst` and `expired` are 0, the watchdog is disabled, and the key tracker is idle. An idle watchdog never pulses and never sets `expired`.
- R2: Writing 0x3333 and then 0xCCCC on consecutive accepted writes arms the register. The next write of any value becomes the control word, and the same write restarts the count from zero.
- R3: Writing 0xAAAA and then 0x5555 on consecutive writes restarts the count from zero and clears `expired`. It leaves the control word unchanged.
- R4: When the tracker is idle, a single write of any value other than 0x3333 or 0xAAAA has no effect on the count, the control word or `expired`.
- R5: A write that does not continue a started key sequence returns the tracker to idle and has no other effect. In particular, 0x3333 followed by anything other than 0xCCCC does not arm, and 0xAAAA followed by anything other than 0x5555 does not service.
- R6: Control bit 15 enables counting and expiry. Control bit 14 enables the reset pulse. With bit 15 set and bit 14 clear, expiry sets `expired` but `wdt_rst` stays low.
- R7: Timeout bit k (bits 1 up to SEL_W) selects a period of 2^(BASE_EXP+k) clock cycles, counted from the restart edge to the edge that raises `wdt_rst` and `expired`. If no timeout bit in 1..SEL_W is set, nothing counts. Bit 0 is not a timeout bit.
- R8: If several timeout bits are set, the lowest one sets the period.
- R9: `wdt_rst` is high for exactly one cycle per expiry. While the watchdog stays enabled and unserviced, it expires again every period.
- R10: The unlock key followed by 0 disables the watchdog. No further pulse occurs, and `expired` keeps its value.
- R11: `expired` stays set until a service sequence or reset clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock; the count advances once per cycle |
| rst | input | 1 | Asynchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control address |
| wr_data | input | 16 | Data word written to the control address |
| wdt_rst | output | 1 | One-cycle reset pulse on expiry |
| expired | output | 1 | Sticky flag, set on expiry |

## Verification
The assertions assume that `wr_data` is a known value in every cycle where `wr_en` is high. They also assume that BASE_EXP is at least 1, so a period spans at least two cycles and two pulses can never be adjacent. The bench drives writes only at the falling edge, with known data, and issues key pairs on consecutive edges. It shrinks BASE_EXP to 3 so that periods of 16 to 64 cycles make every expiry visible. A scoreboard holds the exact cycle at which each pulse is expected, so any extra, early, late or missing pulse is reported.

// File: rtl/wdt_key_pkg.sv
package wdt_key_pkg;

    localparam int CTRL_W = 16;
    localparam int IDX_W  = 4;

    localparam logic [CTRL_W-1:0] UNLOCK_FIRST  = 16'h3333;
    localparam logic [CTRL_W-1:0] UNLOCK_SECOND = 16'hCCCC;
    localparam logic [CTRL_W-1:0] KICK_FIRST    = 16'hAAAA;
    localparam logic [CTRL_W-1:0] KICK_SECOND   = 16'h5555;

    localparam int RUN_BIT = 15;
    localparam int ACT_BIT = 14;

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_UNLOCK1,
        KS_ARMED,
        KS_KICK1
    } key_state_e;

    typedef struct packed {
        logic             run_en;
        logic             act_en;
        logic [IDX_W-1:0] sel_idx;
    } wd_cfg_t;

    // lowest set timeout bit in 1..sel_w, zero when none is set
    function automatic logic [IDX_W-1:0] lowest_sel(input logic [CTRL_W-1:0] w,
                                                    input int sel_w);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int k = sel_w; k >= 1; k--) begin
            if (w[k]) r = IDX_W'(k);
        end
        return r;
    endfunction

endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
    import wdt_key_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic              cfg_load,
    output logic              kick_hit
);

    key_state_e state_q, state_d;

    always_comb begin
        state_d  = state_q;
        cfg_load = 1'b0;
        kick_hit = 1'b0;
        if (wr_en) begin
            unique case (state_q)
                KS_IDLE: begin
                    if (wr_data == UNLOCK_FIRST)     state_d = KS_UNLOCK1;
                    else if (wr_data == KICK_FIRST)  state_d = KS_KICK1;
                end
                KS_UNLOCK1: state_d = (wr_data == UNLOCK_SECOND) ? KS_ARMED : KS_IDLE;
                KS_ARMED: begin
                    cfg_load = 1'b1;
                    state_d  = KS_IDLE;
                end
                KS_KICK1: begin
                    kick_hit = (wr_data == KICK_SECOND);
                    state_d  = KS_IDLE;
                end
                default: state_d = KS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) state_q <= KS_IDLE;
        else     state_q <= state_d;
    end

    // R2
    armed_consumed_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == KS_ARMED && wr_en) |=> (state_q == KS_IDLE));

    // R4
    idle_stray_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == KS_IDLE && wr_en && wr_data != UNLOCK_FIRST && wr_data != KICK_FIRST)
        |=> (state_q == KS_IDLE));

    // R5
    broken_unlock_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == KS_UNLOCK1 && wr_en && wr_data != UNLOCK_SECOND) |=> (state_q == KS_IDLE));

    // R3
    load_kick_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(cfg_load && kick_hit));

endmodule

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
    import wdt_key_pkg::*;
#(
    parameter int SEL_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [CTRL_W-1:0] ctrl_in,
    output wd_cfg_t           cfg_q,
    output logic              count_run
);

    wd_cfg_t cfg_d;

    always_comb begin
        cfg_d.run_en  = ctrl_in[RUN_BIT];
        cfg_d.act_en  = ctrl_in[ACT_BIT];
        cfg_d.sel_idx = lowest_sel(ctrl_in, SEL_W);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst)           cfg_q <= '0;
        else if (cfg_load) cfg_q <= cfg_d;
    end

    assign count_run = cfg_q.run_en && (cfg_q.sel_idx != '0);

    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_load |=> $stable(cfg_q));

endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter
    import wdt_key_pkg::*;
#(
    parameter int BASE_EXP = 23,
    parameter int SEL_W    = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             kick,
    input  logic             restart,
    input  logic             count_run,
    input  logic             act_en,
    input  logic [IDX_W-1:0] sel_idx,
    output logic             wdt_rst,
    output logic             expired
);

    localparam int CNT_W = BASE_EXP + SEL_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] one_w;

    assign one_w = CNT_W'(1);
    assign limit = (one_w << (CNT_W'(BASE_EXP) + CNT_W'(sel_idx))) - one_w;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt_q   <= '0;
            wdt_rst <= 1'b0;
            expired <= 1'b0;
        end else begin
            wdt_rst <= 1'b0;
            if (kick) begin
                cnt_q   <= '0;
                expired <= 1'b0;
            end else if (restart) begin
                cnt_q <= '0;
            end else if (count_run) begin
                if (cnt_q == limit) begin
                    cnt_q   <= '0;
                    expired <= 1'b1;
                    wdt_rst <= act_en;
                end else begin
                    cnt_q <= cnt_q + one_w;
                end
            end
        end
    end

    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |=> !wdt_rst);

    // R6
    pulse_marks_expiry_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |-> expired);

    // R6
    idle_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (!count_run || !act_en) |=> !wdt_rst);

    // R11
    expired_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (expired && !kick) |=> expired);

    // R3
    kick_restart_chk: assert property (@(posedge clk) disable iff (rst)
        kick |=> (cnt_q == '0 && !expired));

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_key_pkg::*;
#(
    parameter int BASE_EXP = 23,
    parameter int SEL_W    = 7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic        wdt_rst,
    output logic        expired
);

    logic    cfg_load;
    logic    kick_hit;
    logic    count_run;
    wd_cfg_t cfg_q;

    wdt_key_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .cfg_load (cfg_load),
        .kick_hit (kick_hit)
    );

    wdt_cfg_reg #(.SEL_W(SEL_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_load  (cfg_load),
        .ctrl_in   (wr_data),
        .cfg_q     (cfg_q),
        .count_run (count_run)
    );

    wdt_tick_counter #(.BASE_EXP(BASE_EXP), .SEL_W(SEL_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .kick      (kick_hit),
        .restart   (cfg_load),
        .count_run (count_run),
        .act_en    (cfg_q.act_en),
        .sel_idx   (cfg_q.sel_idx),
        .wdt_rst   (wdt_rst),
        .expired   (expired)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!wdt_rst && !expired));

endmodule

// File: tb/tb_wdt_keyed.sv
module tb_wdt_keyed;

    localparam int BASE = 3;
    localparam int SELW = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wdt_rst;
    logic        expired;

    always #10 clk = ~clk;

    wdt_keyed #(.BASE_EXP(BASE), .SEL_W(SELW)) dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wdt_rst (wdt_rst),
        .expired (expired)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;
    int last_edge = 0;
    bit done = 0;

    typedef struct {
        int    at;
        string tag;
    } exp_t;
    exp_t sb[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp_v);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // driver side: caller is always at a falling edge
    task automatic wr(input logic [15:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        last_edge = cyc;
        wr_en = 1'b0;
    endtask

    task automatic program_word(input logic [15:0] d);
        wr(16'h3333);
        wr(16'hCCCC);
        wr(d);
    endtask

    task automatic kick();
        wr(16'hAAAA);
        wr(16'h5555);
    endtask

    task automatic expect_at(input int t, input string tag);
        exp_t e;
        e.at  = t;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // monitor side: pops expected pulse cycles
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (wdt_rst) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R4 R10", "unexpected pulse at cycle", cyc, -1);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.at == cyc, e.tag, "pulse cycle", cyc, e.at);
                end
            end else if (sb.size() > 0 && sb[0].at < cyc) begin
                exp_t e;
                e = sb.pop_front();
                check(1'b0, e.tag, "missing pulse, now at cycle", cyc, e.at);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R1 watchdog timeout actual=%0d expected=%0d", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        int n;
        int s;
        repeat (3) @(negedge clk);
        // R1: outputs quiet under reset
        check(wdt_rst == 1'b0, "R1", "wdt_rst in reset", wdt_rst, 0);
        check(expired == 1'b0, "R1", "expired in reset", expired, 0);
        rst = 1'b0;
        repeat (40) @(negedge clk);
        check(expired == 1'b0, "R1", "expired after idle", expired, 0);

        // R4: stray single writes while idle
        wr(16'hCCCC);
        wr(16'hC002);
        wr(16'h5555);
        wr(16'h8001);
        repeat (60) @(negedge clk);
        check(expired == 1'b0, "R4", "expired after stray writes", expired, 0);

        // R5: broken unlock sequences
        wr(16'h3333);
        wr(16'h1234);
        wr(16'hC002);
        wr(16'h3333);
        wr(16'h3333);
        wr(16'hCCCC);
        wr(16'hC002);
        repeat (60) @(negedge clk);
        check(expired == 1'b0, "R5", "expired after broken unlock", expired, 0);

        // R2 R7 R9: program bit 1 -> 16 cycles, repeating
        program_word(16'hC002);
        n = last_edge;
        expect_at(n + 16, "R2");
        expect_at(n + 32, "R9");
        wait_to(n + 15);
        check(expired == 1'b0, "R7", "expired one cycle early", expired, 0);
        wait_to(n + 16);
        check(expired == 1'b1, "R7", "expired at period", expired, 1);
        wait_to(n + 40);
        check(expired == 1'b1, "R11", "expired held", expired, 1);

        // R3: service restarts count and clears flag
        kick();
        s = last_edge;
        check(expired == 1'b0, "R3", "expired after service", expired, 0);
        expect_at(s + 16, "R3");
        wait_to(s + 17);

        // R10: disable via unlock and zero
        program_word(16'h0000);
        repeat (100) @(negedge clk);
        check(expired == 1'b1, "R10", "expired kept after disable", expired, 1);

        // R8: several timeout bits, lowest (bit 2) wins -> 32 cycles
        kick();
        program_word(16'hC00C);
        n = last_edge;
        expect_at(n + 32, "R8");
        wait_to(n + 33);
        program_word(16'h0000);
        repeat (20) @(negedge clk);

        // R6: counting without reset action
        kick();
        program_word(16'h8002);
        n = last_edge;
        wait_to(n + 15);
        check(expired == 1'b0, "R6", "expired before period", expired, 0);
        wait_to(n + 16);
        check(expired == 1'b1, "R6", "expired without pulse", expired, 1);
        wait_to(n + 40);
        program_word(16'h0000);

        // R5: broken service leaves the count running
        kick();
        program_word(16'hC004);
        n = last_edge;
        expect_at(n + 32, "R5");
        repeat (5) @(negedge clk);
        wr(16'hAAAA);
        wr(16'h1234);
        wr(16'h5555);
        wr(16'h5555);
        wait_to(n + 33);
        check(expired == 1'b1, "R5", "expired after broken service", expired, 1);
        program_word(16'h0000);

        // R7: enabled with no timeout bit selected
        kick();
        program_word(16'hC001);
        repeat (100) @(negedge clk);
        check(expired == 1'b0, "R7", "expired with empty timeout field", expired, 0);
        program_word(16'h0000);

        // R2: a new control word restarts the count
        program_word(16'hC002);
        repeat (10) @(negedge clk);
        program_word(16'hC003);
        n = last_edge;
        expect_at(n + 16, "R2");
        wait_to(n + 17);
        program_word(16'h0000);

        // R1: reset in the middle of a run
        kick();
        program_word(16'hC002);
        repeat (8) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(wdt_rst == 1'b0, "R1", "wdt_rst after mid reset", wdt_rst, 0);
        check(expired == 1'b0, "R1", "expired after mid reset", expired, 0);
        rst = 1'b0;
        repeat (40) @(negedge clk);
        check(expired == 1'b0, "R1", "expired stays clear after reset", expired, 0);

        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(1'b0, e.tag, "pulse never seen", -1, e.at);
        end
        done = 1;
        summary();
        $finish;
    end

endmodule